// File: doc/BRIEF.md
# SPI Flash Chip-Erase Sequencer

This block is a host-side SPI master that carries out one full chip erase on a serial flash after a single-cycle `start` pulse. It first sends the write-enable command in its own transaction. Next it sends the erase opcode in a second transaction. It then opens a third transaction that sends the read-status opcode and keeps clocking status bytes until the busy flag in the returned byte is clear. Chip enable goes high between transactions, so the flash acts on each command as it ends.

The SPI clock comes from a divider of the system clock. It idles low and the flash samples on its rising edge. After each transaction, chip enable stays high for a programmable number of system clocks. A status poll that never sees the busy flag clear is cut off after a programmable number of status bytes. The sequence then ends with a one-cycle `error` pulse instead of `done`.

Top module: `flash_erase_seq`

## Requirements
- R1: A `start` pulse seen while idle opens the first transaction, which carries the write-enable byte 0x06, most significant bit first.
- R2: The second transaction carries the erase opcode given by parameter ERASE_OP (0x60 or 0xC7), most significant bit first. It follows the write-enable, so the flash runs exactly one erase per sequence.
- R3: Each command has its own chip-enable-low period. Chip enable rises after the eighth bit of the write-enable byte and after the eighth bit of the erase byte, and no clock edge follows inside that period. Between transactions, `cs_n` stays high for at least CS_GAP system clocks.
- R4: The third transaction sends 0x05 and then reads status bytes back to back while chip enable stays low. Busy is bit 0 of each status byte. After the first status byte with bit 0 equal to 0, `cs_n` rises and `done` pulses for one cycle in that same cycle.
- R5: `sck` is low whenever `cs_n` is high. `mosi` changes only while `sck` is low. `miso` is sampled on the rising edge of `sck`.
- R6: With the timeout enabled, if MAX_POLLS status bytes in a row all report busy, `cs_n` rises and `error` pulses for one cycle. `done` does not pulse, and the block returns to idle. A busy flag that clears on the last allowed status byte still ends with `done`.
- R7: A `start` pulse that arrives while a sequence is running has no effect. The sequence in progress keeps its three transactions and starts no new ones.
- R8: During reset, and on the first cycle after it, `cs_n` is 1 and `sck`, `mosi`, `done` and `error` are 0. A reset in the middle of a sequence returns the pins to that state.
- R9: `done` and `error` are never high together, and each is high for one cycle only.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Single-cycle request to run a chip erase |
| done | output | 1 | One-cycle pulse: erase finished, busy flag clear |
| error | output | 1 | One-cycle pulse: poll limit reached while still busy |
| sck | output | 1 | SPI clock, idles low |
| cs_n | output | 1 | Flash chip enable, active low |
| mosi | output | 1 | Serial data to the flash |
| miso | input | 1 | Serial data from the flash |

## Verification
The bench drives a behavioural flash model. The model decodes every transaction from the pins and executes the erase only when a write-enable came first and chip enable rose after exactly eight bits. A design that merged transactions, counted bits wrongly or reversed the bit order therefore shows no erase, or the wrong opcode log. The model reports busy for a chosen number of status bytes, random or directed. The directed values are zero, one short of the poll limit, and exactly at the limit. An off-by-one in the poll counter then reports error where done was due, or the reverse, and reads the wrong number of status bytes. The bench also measures the chip-enable-high gaps, watches for `sck` high while deselected, sends a stray `start` mid-sequence, and applies a reset during polling.

// File: rtl/flash_erase_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the chip-erase sequencer.
// Assumes: byte-wide SPI commands, sent most significant bit first.
package flash_erase_pkg;
    localparam int unsigned BYTE_BITS = 8;

    localparam logic [BYTE_BITS-1:0] CMD_WRITE_EN = 8'h06;
    localparam logic [BYTE_BITS-1:0] CMD_STATUS   = 8'h05;
    localparam logic [BYTE_BITS-1:0] CMD_FILLER   = 8'h00;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_WREN,
        SQ_GAP,
        SQ_ERASE,
        SQ_STCMD,
        SQ_POLL
    } seq_state_t;
endpackage

// File: rtl/erase_sck_div.sv
`timescale 1ns/1ps
// Makes the tick that advances each SPI clock half-period.
// Assumes: HALF_DIV >= 1. A value of 1 ticks every system clock.
module erase_sck_div #(
    parameter int unsigned HALF_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int unsigned CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    generate
        if (HALF_DIV == 1) begin : g_full_rate
            assign tick = 1'b1;
        end else begin : g_divided
            logic [CW-1:0] cnt;
            // Free-running count that wraps once per half-period.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    cnt <= '0;
                end else if (cnt == CW'(HALF_DIV - 1)) begin
                    cnt <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
            assign tick = (cnt == CW'(HALF_DIV - 1));
        end
    endgenerate
endmodule

// File: rtl/erase_spi_shifter.sv
`timescale 1ns/1ps
// Moves one byte each way with SCK idle low: it drives on the low phase
// and samples on the rising edge.
// Assumes: load arrives only while inactive; chip enable is handled above.
module erase_spi_shifter
    import flash_erase_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick,
    input  logic                 load,
    input  logic [BYTE_BITS-1:0] tx_byte,
    input  logic                 miso,
    output logic                 sck,
    output logic                 mosi,
    output logic [BYTE_BITS-1:0] rx_byte,
    output logic                 byte_done
);
    localparam int unsigned BW = $clog2(BYTE_BITS);

    logic [BYTE_BITS-1:0] tx_sh;
    logic [BYTE_BITS-1:0] rx_sh;
    logic [BW-1:0]        bit_cnt;
    logic                 active;
    logic                 sck_q;

    // Bit engine: rise samples miso, fall shifts the next bit out or ends the byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_sh     <= '0;
            rx_sh     <= '0;
            bit_cnt   <= '0;
            active    <= 1'b0;
            sck_q     <= 1'b0;
            byte_done <= 1'b0;
        end else begin
            byte_done <= 1'b0;
            if (load) begin
                tx_sh   <= tx_byte;
                bit_cnt <= '0;
                sck_q   <= 1'b0;
                active  <= 1'b1;
            end else if (active && tick) begin
                if (!sck_q) begin
                    sck_q <= 1'b1;
                    rx_sh <= {rx_sh[BYTE_BITS-2:0], miso};
                end else begin
                    sck_q <= 1'b0;
                    if (bit_cnt == BW'(BYTE_BITS - 1)) begin
                        active    <= 1'b0;
                        byte_done <= 1'b1;
                    end else begin
                        bit_cnt <= bit_cnt + 1'b1;
                        tx_sh   <= {tx_sh[BYTE_BITS-2:0], 1'b0};
                    end
                end
            end
        end
    end

    assign sck     = sck_q;
    assign mosi    = tx_sh[BYTE_BITS-1];
    assign rx_byte = rx_sh;

    // R5: data toward the flash holds still while SCK is high.
    p_mosi_steady_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sck && $past(sck)) |-> $stable(mosi));

    // R5: a byte ends with SCK back at its idle level.
    p_end_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        byte_done |-> !sck);
endmodule

// File: rtl/flash_erase_seq.sv
`timescale 1ns/1ps
// Chip-erase sequencer: write-enable, erase, then status polling until idle.
// Assumes: start is a one-cycle pulse; CS_GAP >= 1; MAX_POLLS >= 1;
// the flash reports busy in status bit BUSY_BIT.
module flash_erase_seq
    import flash_erase_pkg::*;
#(
    parameter logic [7:0]  ERASE_OP   = 8'hC7,
    parameter int unsigned HALF_DIV   = 4,
    parameter int unsigned CS_GAP     = 8,
    parameter int unsigned MAX_POLLS  = 65536,
    parameter bit          TIMEOUT_EN = 1'b1,
    parameter int unsigned BUSY_BIT   = 0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic done,
    output logic error,
    output logic sck,
    output logic cs_n,
    output logic mosi,
    input  logic miso
);
    localparam int unsigned GW = $clog2(CS_GAP + 1);
    localparam int unsigned PW = $clog2(MAX_POLLS + 1);
    localparam logic [BYTE_BITS-1:0] BUSY_MASK = BYTE_BITS'(1) << BUSY_BIT;

    seq_state_t           state, after_gap;
    logic [GW-1:0]        gap_cnt;
    logic [PW-1:0]        poll_cnt;
    logic                 cs_q, done_q, err_q, load_q;
    logic [BYTE_BITS-1:0] tx_q, rx_byte;
    logic                 tick, byte_done, still_busy, limit_hit;

    erase_sck_div #(.HALF_DIV(HALF_DIV)) u_div (
        .clk(clk), .rst_n(rst_n), .tick(tick)
    );

    erase_spi_shifter u_shift (
        .clk(clk), .rst_n(rst_n), .tick(tick), .load(load_q),
        .tx_byte(tx_q), .miso(miso), .sck(sck), .mosi(mosi),
        .rx_byte(rx_byte), .byte_done(byte_done)
    );

    assign still_busy = |(rx_byte & BUSY_MASK);

    generate
        if (TIMEOUT_EN) begin : g_limit
            assign limit_hit = (poll_cnt == PW'(MAX_POLLS - 1));
            // R6: the poll count never passes the limit.
            p_poll_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
                poll_cnt < PW'(MAX_POLLS));
        end else begin : g_no_limit
            assign limit_hit = 1'b0;
        end
    endgenerate

    // Sequence control: opens and closes the three transactions and reports the outcome.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= SQ_IDLE;
            after_gap <= SQ_IDLE;
            gap_cnt   <= '0;
            poll_cnt  <= '0;
            cs_q      <= 1'b1;
            done_q    <= 1'b0;
            err_q     <= 1'b0;
            load_q    <= 1'b0;
            tx_q      <= '0;
        end else begin
            load_q <= 1'b0;
            done_q <= 1'b0;
            err_q  <= 1'b0;
            case (state)
                SQ_IDLE: if (start) begin
                    cs_q   <= 1'b0;
                    tx_q   <= CMD_WRITE_EN;
                    load_q <= 1'b1;
                    state  <= SQ_WREN;
                end
                SQ_WREN, SQ_ERASE: if (byte_done) begin
                    cs_q      <= 1'b1;
                    gap_cnt   <= '0;
                    after_gap <= (state == SQ_WREN) ? SQ_ERASE : SQ_STCMD;
                    state     <= SQ_GAP;
                end
                SQ_GAP: if (gap_cnt == GW'(CS_GAP - 1)) begin
                    cs_q   <= 1'b0;
                    load_q <= 1'b1;
                    tx_q   <= (after_gap == SQ_ERASE) ? ERASE_OP : CMD_STATUS;
                    state  <= after_gap;
                end else begin
                    gap_cnt <= gap_cnt + 1'b1;
                end
                SQ_STCMD: if (byte_done) begin
                    tx_q     <= CMD_FILLER;
                    load_q   <= 1'b1;
                    poll_cnt <= '0;
                    state    <= SQ_POLL;
                end
                SQ_POLL: if (byte_done) begin
                    if (!still_busy) begin
                        cs_q   <= 1'b1;
                        done_q <= 1'b1;
                        state  <= SQ_IDLE;
                    end else if (limit_hit) begin
                        cs_q   <= 1'b1;
                        err_q  <= 1'b1;
                        state  <= SQ_IDLE;
                    end else begin
                        poll_cnt <= poll_cnt + 1'b1;
                        tx_q     <= CMD_FILLER;
                        load_q   <= 1'b1;
                    end
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

    assign cs_n  = cs_q;
    assign done  = done_q;
    assign error = err_q;

    // Gap monitor: counts deselected cycles, saturating at the minimum gap.
    logic [GW-1:0] hi_cnt;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_cnt <= GW'(CS_GAP);
        end else if (!cs_n) begin
            hi_cnt <= '0;
        end else if (hi_cnt != GW'(CS_GAP)) begin
            hi_cnt <= hi_cnt + 1'b1;
        end
    end

    // R3: chip enable falls only after the full minimum high time.
    p_cs_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> (hi_cnt >= GW'(CS_GAP)));

    // R5: SCK stays at its idle level while the flash is deselected.
    p_sck_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sck);

    // R4: done coincides with a deselected flash.
    p_done_cs_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> cs_n);

    // R9: the two outcomes exclude each other and last one cycle.
    p_outcome_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && error));
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_err_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        error |=> !error);
endmodule

// File: tb/flash_erase_seq_test.sv
`timescale 1ns/1ps
// Bench: a behavioural flash model on the pins, runs with random and directed busy lengths.
module flash_erase_seq_test;
    localparam logic [7:0] ERASE_CODE = 8'h60;
    localparam int         DIV        = 2;
    localparam int         GAP        = 5;
    localparam int         LIMIT      = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic miso = 1'b0;
    logic done, error, sck, cs_n, mosi;

    int checks = 0;
    int errors = 0;

    flash_erase_seq #(
        .ERASE_OP(ERASE_CODE), .HALF_DIV(DIV), .CS_GAP(GAP),
        .MAX_POLLS(LIMIT), .TIMEOUT_EN(1'b1), .BUSY_BIT(0)
    ) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .done(done), .error(error),
        .sck(sck), .cs_n(cs_n), .mosi(mosi), .miso(miso)
    );

    always #2.5 clk = ~clk;

    // Flash model state
    logic       clr = 1'b0;
    int         plan_busy = 0;
    logic       prev_sck, prev_cs;
    int         bits, sidx, busy_left, loads, txns, erases;
    int         gap_cyc, short_gaps, idle_viol, done_cyc, err_cyc, both_cyc;
    logic       wel;
    logic [7:0] cmd, obyte;
    logic [7:0] ops [0:7];

    // Model: decodes the pins at negedge, drives miso after falling SCK edges.
    always @(negedge clk) begin
        if (clr) begin
            prev_sck = 1'b0; prev_cs = 1'b1; bits = 0; sidx = 0; busy_left = 0;
            loads = 0; txns = 0; erases = 0; gap_cyc = GAP; short_gaps = 0;
            idle_viol = 0; done_cyc = 0; err_cyc = 0; both_cyc = 0; wel = 1'b0;
            cmd = 8'h00; obyte = 8'h00; miso = 1'b0;
            for (int i = 0; i < 8; i++) ops[i] = 8'hxx;
        end else begin
            if (done) done_cyc++;
            if (error) err_cyc++;
            if (done && error) both_cyc++;
            if (cs_n && sck) idle_viol++;
            if (prev_cs && !cs_n) begin
                if (gap_cyc < GAP) short_gaps++;
                bits = 0; sidx = 0; gap_cyc = 0;
            end else if (cs_n) begin
                gap_cyc++;
            end
            if (!cs_n && !prev_sck && sck) begin
                if (bits < 8) cmd = {cmd[6:0], mosi};
                bits++;
            end
            if (!cs_n && prev_sck && !sck && bits >= 8 && cmd == 8'h05) begin
                if (sidx == 0) begin
                    obyte = {7'b0, busy_left > 0};
                    if (busy_left > 0) busy_left--;
                    loads++;
                end
                miso = obyte[7 - sidx];
                sidx = (sidx + 1) % 8;
            end
            if (!prev_cs && cs_n) begin
                if (txns < 8) ops[txns] = cmd;
                txns++;
                if (bits == 8 && cmd == 8'h06) wel = 1'b1;
                if (bits == 8 && cmd == ERASE_CODE && wel) begin
                    erases++; busy_left = plan_busy; wel = 1'b0;
                end
            end
            prev_sck = sck;
            prev_cs  = cs_n;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Expected outcome of a run where the flash stays busy for n status bytes.
    function automatic bit exp_done(input int n);
        return n < LIMIT;
    endfunction
    // Status bytes the model prepares: every byte read plus the one begun by the last falling edge.
    function automatic int exp_loads(input int n);
        return (n < LIMIT) ? n + 2 : LIMIT + 1;
    endfunction

    task automatic clear_model();
        @(posedge clk); #1 clr = 1'b1;
        @(posedge clk); #1 clr = 1'b0;
    endtask

    task automatic run_case(input int n, input bit stray_start);
        int cyc;
        plan_busy = n;
        clear_model();
        @(posedge clk); #1 start = 1'b1;
        @(posedge clk); #1 start = 1'b0;
        cyc = 0;
        while (!(done || error) && cyc < 20000) begin
            @(posedge clk); #1;
            cyc++;
            // R7: a second request while busy must not disturb anything
            if (stray_start && cyc == 60) start = 1'b1;
            else start = 1'b0;
        end
        start = 1'b0;
        check(cyc < 20000, "R4 completion seen", cyc, 20000);
        repeat (200) @(posedge clk);
        #1;
        check(ops[0] == 8'h06, "R1 first opcode", ops[0], 8'h06);
        check(ops[1] == ERASE_CODE, "R2 erase opcode", ops[1], ERASE_CODE);
        check(erases == 1, "R2 erase executed", erases, 1);
        check(ops[2] == 8'h05, "R4 status opcode", ops[2], 8'h05);
        check(txns == 3, "R3 R7 transaction count", txns, 3);
        check(short_gaps == 0, "R3 chip-enable gap", short_gaps, 0);
        check(idle_viol == 0, "R5 sck idle while deselected", idle_viol, 0);
        check(loads == exp_loads(n), "R4 R6 status bytes", loads, exp_loads(n));
        check(done_cyc == (exp_done(n) ? 1 : 0), "R4 done pulse", done_cyc, exp_done(n) ? 1 : 0);
        check(err_cyc == (exp_done(n) ? 0 : 1), "R6 error pulse", err_cyc, exp_done(n) ? 0 : 1);
        check(both_cyc == 0, "R9 exclusive outcome", both_cyc, 0);
        check(cs_n == 1'b1, "R3 deselected at end", cs_n, 1);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(150000 * 5);
        errors++;
        checks++;
        $display("FAIL watchdog: actual expired expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int seed_sink;
        seed_sink = $urandom(32'd20240611);
        clr = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        // R8: pins at reset
        check(cs_n == 1'b1 && sck == 1'b0 && mosi == 1'b0, "R8 pins in reset", {cs_n, sck, mosi}, 3'b100);
        check(done == 1'b0 && error == 1'b0, "R8 outcome in reset", {done, error}, 0);
        rst_n = 1'b1;
        clr = 1'b0;
        @(posedge clk); #1;
        check(cs_n == 1'b1 && sck == 1'b0, "R8 after reset", {cs_n, sck}, 2'b10);

        // Directed corner cases
        run_case(0, 1'b0);
        run_case(LIMIT - 1, 1'b0);
        run_case(LIMIT, 1'b0);
        run_case(3, 1'b1);
        // Random busy lengths around the limit
        for (int k = 0; k < 6; k++) run_case(int'($urandom_range(0, LIMIT + 3)), k[0]);

        // R8: reset in the middle of polling
        plan_busy = 1000;
        clear_model();
        @(posedge clk); #1 start = 1'b1;
        @(posedge clk); #1 start = 1'b0;
        repeat (200) @(posedge clk);
        #1 rst_n = 1'b0;
        @(posedge clk); #1;
        check(cs_n == 1'b1 && sck == 1'b0, "R8 mid-run reset", {cs_n, sck}, 2'b10);
        rst_n = 1'b1;
        repeat (100) @(posedge clk); #1;
        check(cs_n == 1'b1 && done == 1'b0, "R8 idle after reset", {cs_n, done}, 2'b10);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule